// File: doc/BRIEF.md
# Demand-Cached Page Mapping Translator

This block turns a logical page number into a physical page number for a flash storage controller. It keeps a small fully associative cache of single page-level mappings on chip. The complete mapping table lives in flash, split into translation pages that each carry 64 consecutive entries. An on-chip directory, indexed by the logical page number shifted right by six bits, gives the flash address of every translation page.

A request names a logical page and may carry a new physical page to store. A hit completes from the cache and never touches flash. A miss reads the translation page that holds the mapping and fills a cache slot, then finishes as a hit. When every slot is in use, the least recently used entry is given up. If that entry is dirty, its translation page is read, patched and written to the next free page of the translation area before the fill goes ahead, and the directory is pointed at the new copy. Flash traffic goes over a single-command request/acknowledge port that carries a whole translation page.

Top module: `mapping_translator`

## Requirements
- R1: A request whose logical page is held in the cache completes with the cached physical page on `doneValid`/`donePpn` and issues no flash command.
- R2: A miss while a slot is free issues exactly one flash read at the directory entry for `lpn >> 6`, takes the mapping from bits `[(lpn % 64)*12 +: 12]` of the returned page, and then completes as a hit.
- R3: A miss while all 16 slots are valid replaces the entry that has gone longest without a completed translation. A clean victim causes no flash write.
- R4: A dirty victim causes a read of its own translation page, a write of that page with the victim's entry replaced, and then the fill read. One translation never needs more than two reads and one write.
- R5: After reset, translation page t is at flash page t, and the append location is 16. Each writeback goes to the append location, which then advances by one, and the victim's directory entry is set to that address so that later reads of that page go there.
- R6: An update request (`reqUpdate`=1) that hits replaces the cached physical page and marks the entry dirty without flash traffic. `donePpn` shows the new value.
- R7: An update request that misses first fills the entry as for a read and then applies the update. The entry is left dirty.
- R8: The block issues one flash command at a time and holds the write flag and address steady until `flashAck`. Read data is taken in the acknowledge cycle.
- R9: Only one translation is in flight. `reqReady` is high only when the block is idle, and a request is taken on a clock edge where `reqValid` and `reqReady` are both high.
- R10: After reset the cache is empty, `reqReady` is high, and `doneValid` and `flashCmdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqLpn | input | 10 | Logical page number |
| reqUpdate | input | 1 | Store `reqPpn` as the new mapping |
| reqPpn | input | 12 | New physical page for an update |
| doneValid | output | 1 | One-cycle completion strobe |
| donePpn | output | 12 | Resulting physical page number |
| flashCmdValid | output | 1 | Flash command pending |
| flashCmdWrite | output | 1 | 1 = page write, 0 = page read |
| flashCmdAddr | output | 6 | Flash page address of the translation page |
| flashWrData | output | 768 | Translation page to write (64 entries of 12 bits) |
| flashAck | input | 1 | Command completed; read data valid this cycle |
| flashRdData | input | 768 | Translation page returned by a read |

## Verification
The bench runs a reference model: a recency-ordered list of cached pages, a dirty set, the expected directory and the append pointer. For every translation it predicts the result and the exact sequence of flash commands, with addresses. Directed steps first compare a cold miss, a repeated hit, update hits and update misses, to show that fills, dirtiness and returned values stay apart. A full cache then takes a clean eviction and a dirty eviction, followed by a re-read of the evicted page, which shows whether the directory really moved to the appended copy. A long sweep over a 24-page pool that spans many translation pages mixes hits, evictions and writebacks. It catches a wrong LRU choice, a wrong entry offset, a lost patch or a stale directory through the returned values and the command sequences.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [1:0] {
    FSEL_WB_RD = 2'd0,
    FSEL_WB_WR = 2'd1,
    FSEL_FILL  = 2'd2
  } flashSel_t;

  typedef struct packed {
    logic      latchReq;
    logic      touch;
    logic      setTgt;
    logic      wbCapture;
    logic      wbCommit;
    logic      fillCommit;
    flashSel_t fsel;
  } mtCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOKUP = 3'd1,
    ST_WB_RD  = 3'd2,
    ST_WB_WR  = 3'd3,
    ST_FILL   = 3'd4
  } mtState_t;

endpackage

// File: rtl/mt_datapath.sv
module mt_datapath
  import mt_pkg::*;
#(
  parameter int LPN_W    = 10,
  parameter int PPN_W    = 12,
  parameter int ENTRIES  = 16,
  parameter int PER_PAGE = 64,
  parameter int FADDR_W  = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mtCtrl_t                     ctrl,
  input  logic [LPN_W-1:0]            reqLpn,
  input  logic                        reqUpdate,
  input  logic [PPN_W-1:0]            reqPpn,
  output logic                        hit,
  output logic                        missDirty,
  output logic [PPN_W-1:0]            donePpn,
  output logic [FADDR_W-1:0]          flashCmdAddr,
  output logic [PER_PAGE*PPN_W-1:0]   flashWrData,
  input  logic [PER_PAGE*PPN_W-1:0]   flashRdData
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int OFF_W  = $clog2(PER_PAGE);
  localparam int TP_W   = LPN_W - OFF_W;
  localparam int NUM_TP = 1 << TP_W;
  localparam int PAGE_W = PER_PAGE * PPN_W;
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld, dty;
  logic [LPN_W-1:0]   lpnArr [ENTRIES];
  logic [PPN_W-1:0]   ppnArr [ENTRIES];
  logic [IDX_W-1:0]   age    [ENTRIES];

  logic [LPN_W-1:0]   rLpn;
  logic               rUpd;
  logic [PPN_W-1:0]   rPpn;
  logic [IDX_W-1:0]   tgt;

  logic [FADDR_W-1:0] dir [NUM_TP];
  logic [FADDR_W-1:0] appendPtr;
  logic [PAGE_W-1:0]  pageBuf;

  logic [ENTRIES-1:0] hitVec, maxMask;
  logic [IDX_W-1:0]   hitIdx, freeIdx, victimIdx;
  logic               hasFree;

  always_comb begin
    hitIdx    = '0;
    victimIdx = '0;
    freeIdx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hitVec[i]  = vld[i] && (lpnArr[i] == rLpn);
      maxMask[i] = (age[i] == AGE_MAX);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i])  hitIdx    = IDX_W'(i);
      if (maxMask[i]) victimIdx = IDX_W'(i);
      if (!vld[i])    freeIdx   = IDX_W'(i);
    end
  end

  assign hit       = |hitVec;
  assign hasFree   = ~&vld;
  assign missDirty = !hasFree && dty[victimIdx];

  // victim location within its translation page
  logic [LPN_W-1:0]  victimLpn;
  logic [TP_W-1:0]   vPage, rPage;
  logic [OFF_W-1:0]  vOff, rOff;
  logic [PAGE_W-1:0] patched;

  assign victimLpn = lpnArr[tgt];
  assign vPage     = victimLpn[LPN_W-1:OFF_W];
  assign vOff      = victimLpn[OFF_W-1:0];
  assign rPage     = rLpn[LPN_W-1:OFF_W];
  assign rOff      = rLpn[OFF_W-1:0];

  always_comb begin
    patched = flashRdData;
    patched[vOff*PPN_W +: PPN_W] = ppnArr[tgt];
  end

  always_comb begin
    unique case (ctrl.fsel)
      FSEL_WB_RD: flashCmdAddr = dir[vPage];
      FSEL_WB_WR: flashCmdAddr = appendPtr;
      default:    flashCmdAddr = dir[rPage];
    endcase
  end

  assign flashWrData = pageBuf;

  // request latch, target slot, page buffer, done value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rLpn    <= '0;
      rUpd    <= 1'b0;
      rPpn    <= '0;
      tgt     <= '0;
      pageBuf <= '0;
      donePpn <= '0;
    end else begin
      if (ctrl.latchReq) begin
        rLpn <= reqLpn;
        rUpd <= reqUpdate;
        rPpn <= reqPpn;
      end
      if (ctrl.setTgt)    tgt     <= hasFree ? freeIdx : victimIdx;
      if (ctrl.wbCapture) pageBuf <= patched;
      if (ctrl.touch)     donePpn <= rUpd ? rPpn : ppnArr[hitIdx];
    end
  end

  // cache array and recency ages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
      dty <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        lpnArr[i] <= '0;
        ppnArr[i] <= '0;
        age[i]    <= IDX_W'(i);
      end
    end else begin
      if (ctrl.touch) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == hitIdx)        age[i] <= '0;
          else if (age[i] < age[hitIdx])  age[i] <= age[i] + 1'b1;
        end
        if (rUpd) begin
          ppnArr[hitIdx] <= rPpn;
          dty[hitIdx]    <= 1'b1;
        end
      end
      if (ctrl.wbCommit) begin
        vld[tgt] <= 1'b0;
        dty[tgt] <= 1'b0;
      end
      if (ctrl.fillCommit) begin
        vld[tgt]    <= 1'b1;
        dty[tgt]    <= 1'b0;
        lpnArr[tgt] <= rLpn;
        ppnArr[tgt] <= flashRdData[rOff*PPN_W +: PPN_W];
      end
    end
  end

  // on-chip directory and append location of the translation area
  always_ff @(posedge clk) begin
    if (!rstN) begin
      appendPtr <= FADDR_W'(NUM_TP);
      for (int t = 0; t < NUM_TP; t++) dir[t] <= FADDR_W'(t);
    end else if (ctrl.wbCommit) begin
      dir[vPage] <= appendPtr;
      appendPtr  <= appendPtr + 1'b1;
    end
  end

  assert_one_hit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  assert_lru_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(maxMask));

  assert_fill_hits_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fillCommit |=> hit);

  assert_update_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.touch && rUpd) |=> (dty[$past(hitIdx)] && ppnArr[$past(hitIdx)] == $past(rPpn)));

endmodule

// File: rtl/mt_control.sv
module mt_control
  import mt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    hit,
  input  logic    missDirty,
  output logic    doneValid,
  output logic    flashCmdValid,
  output logic    flashCmdWrite,
  input  logic    flashAck,
  output mtCtrl_t ctrl
);

  mtState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (reqValid) nextState = ST_LOOKUP;
      ST_LOOKUP: if (hit) nextState = ST_IDLE;
                 else if (missDirty) nextState = ST_WB_RD;
                 else nextState = ST_FILL;
      ST_WB_RD:  if (flashAck) nextState = ST_WB_WR;
      ST_WB_WR:  if (flashAck) nextState = ST_FILL;
      ST_FILL:   if (flashAck) nextState = ST_LOOKUP;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneValid <= 1'b0;
    end else begin
      state     <= nextState;
      doneValid <= (state == ST_LOOKUP) && hit;
    end
  end

  assign reqReady      = (state == ST_IDLE);
  assign flashCmdValid = (state == ST_WB_RD) || (state == ST_WB_WR) || (state == ST_FILL);
  assign flashCmdWrite = (state == ST_WB_WR);

  always_comb begin
    ctrl            = '0;
    ctrl.latchReq   = (state == ST_IDLE) && reqValid;
    ctrl.touch      = (state == ST_LOOKUP) && hit;
    ctrl.setTgt     = (state == ST_LOOKUP) && !hit;
    ctrl.wbCapture  = (state == ST_WB_RD) && flashAck;
    ctrl.wbCommit   = (state == ST_WB_WR) && flashAck;
    ctrl.fillCommit = (state == ST_FILL) && flashAck;
    ctrl.fsel       = (state == ST_WB_RD) ? FSEL_WB_RD :
                      (state == ST_WB_WR) ? FSEL_WB_WR : FSEL_FILL;
  end

  // per-translation flash cost counters, used only by the checks below
  logic [1:0] rdCnt, wrCnt;
  always_ff @(posedge clk) begin
    if (!rstN || (reqValid && reqReady)) begin
      rdCnt <= '0;
      wrCnt <= '0;
    end else if (flashCmdValid && flashAck) begin
      if (flashCmdWrite) wrCnt <= wrCnt + 1'b1;
      else               rdCnt <= rdCnt + 1'b1;
    end
  end

  assert_cost_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (rdCnt <= 2'd2 && wrCnt <= 2'd1));

  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (reqReady && !flashCmdValid));

endmodule

// File: rtl/mapping_translator.sv
module mapping_translator
  import mt_pkg::*;
#(
  parameter int LPN_W    = 10,
  parameter int PPN_W    = 12,
  parameter int ENTRIES  = 16,
  parameter int PER_PAGE = 64,
  parameter int FADDR_W  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [LPN_W-1:0]          reqLpn,
  input  logic                      reqUpdate,
  input  logic [PPN_W-1:0]          reqPpn,
  output logic                      doneValid,
  output logic [PPN_W-1:0]          donePpn,
  output logic                      flashCmdValid,
  output logic                      flashCmdWrite,
  output logic [FADDR_W-1:0]        flashCmdAddr,
  output logic [PER_PAGE*PPN_W-1:0] flashWrData,
  input  logic                      flashAck,
  input  logic [PER_PAGE*PPN_W-1:0] flashRdData
);

  mtCtrl_t ctrl;
  logic    hit, missDirty;

  mt_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqReady      (reqReady),
    .hit           (hit),
    .missDirty     (missDirty),
    .doneValid     (doneValid),
    .flashCmdValid (flashCmdValid),
    .flashCmdWrite (flashCmdWrite),
    .flashAck      (flashAck),
    .ctrl          (ctrl)
  );

  mt_datapath #(
    .LPN_W    (LPN_W),
    .PPN_W    (PPN_W),
    .ENTRIES  (ENTRIES),
    .PER_PAGE (PER_PAGE),
    .FADDR_W  (FADDR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .reqLpn       (reqLpn),
    .reqUpdate    (reqUpdate),
    .reqPpn       (reqPpn),
    .hit          (hit),
    .missDirty    (missDirty),
    .donePpn      (donePpn),
    .flashCmdAddr (flashCmdAddr),
    .flashWrData  (flashWrData),
    .flashRdData  (flashRdData)
  );

  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmdValid && !flashAck) |=>
      (flashCmdValid && $stable(flashCmdWrite) && $stable(flashCmdAddr)));

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rstN |=> (reqReady && !doneValid && !flashCmdValid));

endmodule

// File: tb/mapping_translator_tb.sv
module mapping_translator_tb;

  localparam int LPN_W = 10, PPN_W = 12, ENT = 16, PER = 64, FA_W = 6;
  localparam int PAGE_W = PER * PPN_W;
  localparam int NTP = (1 << LPN_W) / PER;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqUpdate = 1'b0;
  logic [LPN_W-1:0] reqLpn = '0;
  logic [PPN_W-1:0] reqPpn = '0;
  logic reqReady, doneValid, flashCmdValid, flashCmdWrite;
  logic [PPN_W-1:0] donePpn;
  logic [FA_W-1:0] flashCmdAddr;
  logic [PAGE_W-1:0] flashWrData;
  logic flashAck = 1'b0;
  logic [PAGE_W-1:0] flashRdData = '0;

  always #10 clk = ~clk;  // 50 MHz

  mapping_translator u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLpn(reqLpn), .reqUpdate(reqUpdate), .reqPpn(reqPpn),
    .doneValid(doneValid), .donePpn(donePpn),
    .flashCmdValid(flashCmdValid), .flashCmdWrite(flashCmdWrite),
    .flashCmdAddr(flashCmdAddr), .flashWrData(flashWrData),
    .flashAck(flashAck), .flashRdData(flashRdData)
  );

  int nChecks = 0, nErr = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference state
  logic [PAGE_W-1:0] flashMem [1 << FA_W];
  int refMap [1 << LPN_W];
  bit dirtyMap [1 << LPN_W];
  int expDir [NTP];
  int expAppend;
  int mru [$];

  function automatic int initPpn(input int lpn);
    return (lpn * 7 + 3) & ((1 << PPN_W) - 1);
  endfunction

  // flash command log
  int  logAddr [8];
  bit  logWr [8];
  int  logN;
  int  waitCnt = 0;
  int  firstAddr;
  bit  firstWr;

  // behavioural flash: acknowledges every command after three cycles
  always @(negedge clk) begin
    if (flashAck) begin
      flashAck = 1'b0;
    end else if (rstN && flashCmdValid) begin
      if (waitCnt == 0) begin
        firstAddr = flashCmdAddr;
        firstWr   = flashCmdWrite;
        check(reqReady == 1'b0, "R9 ready during flash", reqReady, 0);
      end
      waitCnt++;
      if (waitCnt == 3) begin
        waitCnt = 0;
        check(flashCmdAddr == firstAddr && flashCmdWrite == firstWr,
              "R8 command held", flashCmdAddr, firstAddr);
        if (flashCmdWrite) flashMem[flashCmdAddr] = flashWrData;
        else               flashRdData = flashMem[flashCmdAddr];
        if (logN < 8) begin
          logAddr[logN] = flashCmdAddr;
          logWr[logN]   = flashCmdWrite;
        end
        logN++;
        flashAck = 1'b1;
      end
    end
  end

  task automatic doTrans(input int lpn, input bit upd, input int ppn);
    int eAddr [4];
    bit eWr [4];
    int expN;
    int pos;
    int to;
    string tag;
    expN = 0;
    pos  = -1;
    foreach (mru[k]) if (mru[k] == lpn) pos = k;
    if (pos >= 0) begin
      tag = "R1";
      mru.delete(pos);
    end else begin
      tag = "R2";
      if (mru.size() == ENT) begin
        int vic;
        vic = mru.pop_back();
        tag = "R3";
        if (dirtyMap[vic]) begin
          tag = "R4";
          eAddr[0] = expDir[vic / PER]; eWr[0] = 1'b0;
          eAddr[1] = expAppend;         eWr[1] = 1'b1;
          expN = 2;
          expDir[vic / PER] = expAppend;
          expAppend++;
          dirtyMap[vic] = 1'b0;
        end
      end
      eAddr[expN] = expDir[lpn / PER];
      eWr[expN]   = 1'b0;
      expN++;
    end
    mru.push_front(lpn);
    if (upd) begin
      refMap[lpn]   = ppn;
      dirtyMap[lpn] = 1'b1;
      tag = {tag, (pos >= 0) ? "+R6" : "+R7"};
    end

    while (!reqReady) @(negedge clk);
    logN      = 0;
    reqValid  = 1'b1;
    reqLpn    = LPN_W'(lpn);
    reqUpdate = upd;
    reqPpn    = PPN_W'(ppn);
    @(negedge clk);
    reqValid  = 1'b0;
    check(reqReady == 1'b0, "R9 busy after accept", reqReady, 0);
    to = 0;
    while (!doneValid && to < 2000) begin
      @(negedge clk);
      to++;
    end
    check(doneValid == 1'b1, {tag, " done"}, doneValid, 1);
    check(int'(donePpn) == refMap[lpn], {tag, " ppn"}, donePpn, refMap[lpn]);
    check(logN == expN, {tag, " command count"}, logN, expN);
    for (int k = 0; k < expN && k < logN; k++) begin
      check(logWr[k] == eWr[k], {tag, " command kind"}, logWr[k], eWr[k]);
      check(logAddr[k] == eAddr[k], eWr[k] ? "R5 append address" : {tag, " read address"},
            logAddr[k], eAddr[k]);
    end
    @(negedge clk);
    check(doneValid == 1'b0, "R9 done single cycle", doneValid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < (1 << FA_W); t++) flashMem[t] = '0;
    for (int l = 0; l < (1 << LPN_W); l++) begin
      refMap[l]   = initPpn(l);
      dirtyMap[l] = 1'b0;
      flashMem[l / PER][(l % PER) * PPN_W +: PPN_W] = PPN_W'(initPpn(l));
    end
    for (int t = 0; t < NTP; t++) expDir[t] = t;
    expAppend = NTP;
    logN = 0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: idle after reset
    check(reqReady == 1'b1, "R10 ready", reqReady, 1);
    check(doneValid == 1'b0, "R10 done low", doneValid, 0);
    check(flashCmdValid == 1'b0, "R10 no command", flashCmdValid, 0);

    doTrans(5, 0, 0);            // R2 cold miss, page 0
    doTrans(5, 0, 0);            // R1 hit
    doTrans(5, 1, 12'h123);      // R6 update hit
    doTrans(5, 0, 0);            // R1 reads updated value
    doTrans(200, 1, 12'h456);    // R7 update miss on page 3
    doTrans(200, 0, 0);          // R1
    for (int k = 0; k < 14; k++) doTrans(300 + k * 50, 0, 0);  // fill to 16
    doTrans(5, 0, 0);            // make 5 most recent
    doTrans(1000, 0, 0);         // R4: LRU is dirty 200
    doTrans(200, 0, 0);          // R5: fetched from the appended page
    doTrans(301, 0, 0);          // R3: clean eviction
    doTrans(5, 0, 0);            // R1: 5 still resident

    // sweep over a pool wider than the cache
    for (int i = 0; i < 150; i++) begin
      int lp;
      lp = ((i * 7) % 24) * 149 + 11;
      lp = lp % (1 << LPN_W);
      doTrans(lp, (i % 6) == 0, (i * 91 + 5) & 12'hFFF);
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule